// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns one parallel character at a time into an asynchronous serial frame on a single transmit line. A character arrives through a valid/ready handshake. The frame format comes from a set of line-control inputs: character length, stop-bit count, parity on or off, and parity sense. These settings are captured at the moment the character is accepted, so they can change freely while a frame is on the line.

Bit timing comes from an external baud tick that pulses once per oversampling period, sixteen periods to a bit. The frame is a low start bit, then the data bits least significant first, then an optional parity bit and the stop bits. After the stop bits the line returns to a high idle level. With the two-stop setting, a 5-bit character gets one and a half stop bits. The baud-rate divider, the receiver and any character storage sit outside this block.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, `tx_out` is high and `in_ready` is high.
- R2: A character is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the next cycle until the cycle after the final stop tick. `in_valid` has no effect while `in_ready` is low.
- R3: The cycle after acceptance, `tx_out` goes low for the start bit. The start bit, each data bit and the parity bit each last exactly 16 baud ticks.
- R4: `lc_word_len` selects the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits are sent bit 0 first. Bits of `in_data` above the selected length have no effect on the line.
- R5: When `lc_parity_en` is 1, one parity bit follows the last data bit. When it is 0, the stop bits follow the data directly.
- R6: When `lc_parity_even` is 0, the parity bit makes the number of ones odd. When it is 1, it makes that number even. The count covers the data bits and the parity bit, and only the selected data bits take part.
- R7: The stop level is high. It lasts 16 ticks when `lc_two_stop` is 0 and 32 ticks when it is 1. When `lc_two_stop` is 1 and `lc_word_len` is 00, it lasts 24 ticks.
- R8: The line-control inputs and `in_data` are captured at acceptance. Changes to them during a frame do not alter that frame.
- R9: While `in_ready` is high and no character is being accepted, `tx_out` stays high and baud ticks have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| baud_tick | input | 1 | One-cycle pulse per oversampling period (16 per bit) |
| lc_word_len | input | 2 | Character length select (00=5 .. 11=8 bits) |
| lc_two_stop | input | 1 | 0: one stop bit, 1: two stop bits (1.5 with 5-bit characters) |
| lc_parity_en | input | 1 | 1 appends a parity bit |
| lc_parity_even | input | 1 | 0 odd parity, 1 even parity |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character to send |
| in_ready | output | 1 | Framer can accept a character |
| tx_out | output | 1 | Serial transmit line |

## Verification
Some properties can be checked on every cycle: the line is high whenever the framer is ready, an accepted character pulls the line low and drops ready on the next cycle, and neither the line nor ready changes in a cycle without a baud tick. Ready also rises only after a high stop level. The bench scenarios show the rest. These are the exact tick count of every bit and of each stop length including the half bit, data order and masking for all four lengths, both parity senses, and that line-control or data changes and extra valid pulses during a frame are ignored.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

  localparam int TXF_DATA_W   = 8;
  localparam int TXF_MIN_BITS = 5;
  localparam int TXF_IDX_W    = $clog2(TXF_DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txf_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
  } txf_cfg_t;

  function automatic logic [TXF_DATA_W-1:0] txf_mask(input logic [1:0] wlen);
    logic [TXF_DATA_W-1:0] m;
    for (int i = 0; i < TXF_DATA_W; i++) begin
      m[i] = (i < TXF_MIN_BITS + int'(wlen));
    end
    return m;
  endfunction

endpackage

// File: rtl/uart_txf_hold.sv
module uart_txf_hold
  import uart_txf_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int CNT_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  shift,
  input  txf_cfg_t              cfg_in,
  input  logic [TXF_DATA_W-1:0] data_in,
  output logic                  bit0,
  output logic                  bit1,
  output logic [TXF_IDX_W-1:0]  last_idx,
  output logic                  par_en,
  output logic                  par_bit,
  output logic [CNT_W-1:0]      stop_last
);

  txf_cfg_t              cfg_q;
  logic [TXF_DATA_W-1:0] data_q;
  logic                  par_q;
  logic                  par_d;
  logic [TXF_DATA_W-1:0] data_d;

  always_comb begin
    logic ones;
    ones  = ^(data_in & txf_mask(cfg_in.wlen));
    par_d = cfg_in.par_even ? ones : ~ones;
    data_d = data_q;
    if (load)       data_d = data_in;
    else if (shift) data_d = {1'b0, data_q[TXF_DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      data_q <= '0;
      par_q  <= 1'b0;
    end else begin
      if (load) begin
        cfg_q <= cfg_in;
        par_q <= par_d;
      end
      if (load || shift) data_q <= data_d;
    end
  end

  assign bit0     = data_q[0];
  assign bit1     = data_q[1];
  assign last_idx = TXF_IDX_W'(TXF_MIN_BITS - 1) + TXF_IDX_W'(cfg_q.wlen);
  assign par_en   = cfg_q.par_en;
  assign par_bit  = par_q;

  always_comb begin
    if (!cfg_q.two_stop)          stop_last = CNT_W'(OSR - 1);
    else if (cfg_q.wlen == 2'b00) stop_last = CNT_W'(OSR + OSR / 2 - 1);
    else                          stop_last = CNT_W'(2 * OSR - 1);
  end

endmodule

// File: rtl/uart_txf_timer.sv
module uart_txf_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] last,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign done   = tick && !clr && (cnt_q == last);
  assign cnt_en = clr || tick;

  always_comb begin
    if (clr || done) cnt_d = '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uart_txf_seq.sv
module uart_txf_seq
  import uart_txf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 tick_done,
  input  logic [TXF_IDX_W-1:0] last_idx,
  input  logic                 par_en,
  input  logic                 par_bit,
  input  logic                 bit0,
  input  logic                 bit1,
  output logic                 in_ready,
  output logic                 load,
  output logic                 shift,
  output logic                 timer_clr,
  output logic                 in_stop,
  output logic                 tx_out
);

  txf_state_e           state_q, state_d;
  logic [TXF_IDX_W-1:0] idx_q, idx_d;
  logic                 line_q, line_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    line_d  = line_q;
    load    = 1'b0;
    shift   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        line_d = 1'b1;
        if (in_valid) begin
          load    = 1'b1;
          state_d = ST_START;
          line_d  = 1'b0;
        end
      end
      ST_START: begin
        if (tick_done) begin
          state_d = ST_DATA;
          idx_d   = '0;
          line_d  = bit0;
        end
      end
      ST_DATA: begin
        if (tick_done) begin
          if (idx_q == last_idx) begin
            state_d = par_en ? ST_PARITY : ST_STOP;
            line_d  = par_en ? par_bit : 1'b1;
          end else begin
            shift  = 1'b1;
            idx_d  = idx_q + TXF_IDX_W'(1);
            line_d = bit1;
          end
        end
      end
      ST_PARITY: begin
        if (tick_done) begin
          state_d = ST_STOP;
          line_d  = 1'b1;
        end
      end
      ST_STOP: begin
        if (tick_done) begin
          state_d = ST_IDLE;
          line_d  = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        line_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      line_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      line_q  <= line_d;
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign timer_clr = (state_q == ST_IDLE);
  assign in_stop   = (state_q == ST_STOP);
  assign tx_out    = line_q;

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_txf_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [1:0] lc_word_len,
  input  logic       lc_two_stop,
  input  logic       lc_parity_en,
  input  logic       lc_parity_even,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       tx_out
);

  localparam int CNT_W = $clog2(2 * OSR);

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  txf_cfg_t             cfg_in;
  logic                 load, shift, timer_clr, in_stop, tick_done;
  logic                 bit0, bit1, par_en, par_bit;
  logic [TXF_IDX_W-1:0] last_idx;
  logic [CNT_W-1:0]     stop_last, phase_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign cfg_in = '{wlen: lc_word_len, two_stop: lc_two_stop,
                    par_en: lc_parity_en, par_even: lc_parity_even};

  assign phase_last = in_stop ? stop_last : CNT_W'(OSR - 1);

  uart_txf_hold #(.OSR(OSR), .CNT_W(CNT_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (load),
    .shift     (shift),
    .cfg_in    (cfg_in),
    .data_in   (in_data),
    .bit0      (bit0),
    .bit1      (bit1),
    .last_idx  (last_idx),
    .par_en    (par_en),
    .par_bit   (par_bit),
    .stop_last (stop_last)
  );

  uart_txf_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (timer_clr),
    .tick  (baud_tick),
    .last  (phase_last),
    .done  (tick_done)
  );

  uart_txf_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (in_valid),
    .tick_done (tick_done),
    .last_idx  (last_idx),
    .par_en    (par_en),
    .par_bit   (par_bit),
    .bit0      (bit0),
    .bit1      (bit1),
    .in_ready  (in_ready),
    .load      (load),
    .shift     (shift),
    .timer_clr (timer_clr),
    .in_stop   (in_stop),
    .tx_out    (tx_out)
  );

endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic in_valid,
  input logic in_ready,
  input logic tx_out
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx_out);  // R9

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!tx_out && !in_ready));  // R2

  AST_LINE_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !baud_tick) |=> $stable(tx_out));  // R3

  AST_READY_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !baud_tick) |=> !in_ready);  // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (in_ready && tx_out));  // R9

  AST_STOP_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(tx_out));  // R7

endmodule

bind uart_tx_framer uart_tx_framer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .baud_tick (baud_tick),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .tx_out    (tx_out)
);

// File: tb/uart_tx_framer_tb.sv
`timescale 1ns/1ps
module uart_tx_framer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [1:0] lc_word_len = 2'b00;
  logic       lc_two_stop = 1'b0;
  logic       lc_parity_en = 1'b0;
  logic       lc_parity_even = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       tx_out;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  uart_tx_framer u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .baud_tick      (baud_tick),
    .lc_word_len    (lc_word_len),
    .lc_two_stop    (lc_two_stop),
    .lc_parity_en   (lc_parity_en),
    .lc_parity_even (lc_parity_even),
    .in_valid       (in_valid),
    .in_data        (in_data),
    .in_ready       (in_ready),
    .tx_out         (tx_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic logic exp_parity(input logic [7:0] d, input int nb, input logic even);
    logic x = 1'b0;
    for (int i = 0; i < nb; i++) x ^= d[i];
    return even ? x : ~x;
  endfunction

  function automatic int exp_stop_ticks(input logic [1:0] wl, input logic two);
    if (!two) return 16;
    if (wl == 2'b00) return 24;
    return 32;
  endfunction

  task automatic tick_once();
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [1:0] wl,
                            input logic two, input logic pen, input logic pev,
                            input bit noise);
    logic       bits [12];
    int         lens [12];
    string      tags [12];
    int         nph;
    int         nb;
    nb = 5 + int'(wl);
    bits[0] = 1'b0; lens[0] = 16; tags[0] = "R3 start";
    for (int i = 0; i < nb; i++) begin
      bits[1+i] = d[i]; lens[1+i] = 16; tags[1+i] = "R4 data";
    end
    nph = 1 + nb;
    if (pen) begin
      bits[nph] = exp_parity(d, nb, pev); lens[nph] = 16; tags[nph] = "R5 R6 parity";
      nph++;
    end
    bits[nph] = 1'b1; lens[nph] = exp_stop_ticks(wl, two); tags[nph] = "R7 stop";
    nph++;

    @(negedge clk);
    check("R2 ready before accept", in_ready, 1'b1);
    in_valid = 1'b1; in_data = d; lc_word_len = wl; lc_two_stop = two;
    lc_parity_en = pen; lc_parity_even = pev;
    @(negedge clk);
    in_valid = 1'b0;
    if (noise) begin
      lc_word_len = 2'($urandom); lc_two_stop = 1'($urandom);
      lc_parity_en = 1'($urandom); lc_parity_even = 1'($urandom);
      in_data = 8'($urandom);
    end
    for (int p = 0; p < nph; p++) begin
      for (int t = 0; t < lens[p]; t++) begin
        if (noise) in_valid = (p < nph - 1) ? 1'($urandom) : 1'b0;
        check(noise ? {tags[p], " R8 with input changes"} : tags[p], tx_out, bits[p]);
        check("R2 ready low during frame", in_ready, 1'b0);
        tick_once();
      end
    end
    in_valid = 1'b0;
    check("R2 ready after last stop tick", in_ready, 1'b1);
    check("R9 line idle after frame", tx_out, 1'b1);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset tx_out", tx_out, 1'b1);
    check("R1 reset ready", in_ready, 1'b1);

    for (int k = 0; k < 20; k++) begin
      tick_once();
      check("R9 idle ticks line", tx_out, 1'b1);
      check("R9 idle ticks ready", in_ready, 1'b1);
    end

    for (int w = 0; w < 4; w++) begin
      for (int s = 0; s < 2; s++) begin
        send_frame(8'hA5 ^ 8'(w * 17), 2'(w), 1'(s), 1'b1, 1'(w & 1), 1'b0);
        send_frame(8'h3C, 2'(w), 1'(s), 1'b0, 1'b0, 1'b0);
      end
    end
    send_frame(8'hE0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
    send_frame(8'hE0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0);
    send_frame(8'hFF, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
    send_frame(8'h00, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1);

    for (int k = 0; k < 30; k++) begin
      send_frame(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule